// File: doc/BRIEF.md
# Serial Hold Condition Controller

This block sits between the pins of a serial slave port and its shift logic and decides when the port is paused. It samples the chip-select, hold, serial-clock and data pins in the system clock domain and tracks selection. It raises a qualified hold flag only at moments when the serial clock is low. While that flag is up, the block drops the data-output enable and stops serial-clock edges from reaching the shift path. The partially received word and its bit count are kept, so a transfer resumes at the exact bit where it stopped.

Deselecting the port while it is paused counts as an abort. The interface is cleared and held in a locked state. The lock lifts only after the hold pin has been released with the port deselected, and a fresh select edge is then needed to restart. A small receive shifter is included: it assembles words MSB first from the qualified clock edges, so the effect of the freeze can be seen at the ports.

Top module: `hold_cond_ctrl`

## Requirements
- R1: After reset, `hold_active`=0, `locked_out`=0, `iface_clear`=1, `sdo_oe`=0, `rx_count`=0 and `rx_word`=0.
- R2: A falling edge of `cs_n_pin` selects the port (`iface_clear`=0). While the port is selected and not paused, `sdo_oe` equals `tx_oe_in`. While deselected, `sdo_oe`=0 and `iface_clear`=1.
- R3: A low `hold_n_pin` while the port is deselected never raises `hold_active`.
- R4: With the port selected and `sck_pin` low, a low `hold_n_pin` raises `hold_active`. The flag rises on the third system clock edge after the pin change.
- R5: If `hold_n_pin` goes low while `sck_pin` is high, `hold_active` stays 0 until `sck_pin` next goes low.
- R6: Releasing `hold_n_pin` with `sck_pin` low clears `hold_active`. If `sck_pin` is high, the flag stays set until `sck_pin` next goes low.
- R7: While `hold_active`=1, `sdo_oe`=0. Edges on `sck_pin`, and the value of `sdi_pin`, leave `rx_count` and `rx_partial` unchanged.
- R8: After a pause, reception continues from the stored bit count and partial word, so the completed word equals the uninterrupted word.
- R9: Raising `cs_n_pin` during a pause clears `hold_active`, sets `locked_out`=1 and `iface_clear`=1, and returns `rx_count` to 0.
- R10: While `locked_out`=1, selecting the port does not restart it. The lock clears only once `hold_n_pin` and `cs_n_pin` are both high. After that, a new falling edge on `cs_n_pin` selects the port.
- R11: Bits are taken from `sdi_pin` on rising `sck_pin` edges, MSB first. After `WORD_W` bits, `rx_word` takes the assembled word and `rx_count` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_pin | input | 1 | Serial clock pin |
| cs_n_pin | input | 1 | Active-low select pin |
| hold_n_pin | input | 1 | Active-low pause pin |
| sdi_pin | input | 1 | Serial data in pin |
| tx_oe_in | input | 1 | Output enable requested by the transmit path |
| hold_active | output | 1 | Qualified pause flag; freezes the shift path |
| iface_clear | output | 1 | Interface held cleared (deselected or locked) |
| locked_out | output | 1 | Set after deselection during a pause |
| sdo_oe | output | 1 | Gated enable for the serial data output driver |
| sck_rise_ok | output | 1 | Qualified rising serial clock pulse |
| sck_fall_ok | output | 1 | Qualified falling serial clock pulse |
| rx_word | output | WORD_W | Last completed received word |
| rx_partial | output | WORD_W | Shift register holding the word in progress |
| rx_count | output | CNT_W | Bits received of the word in progress |

## Verification
Two events can land in the same system clock cycle: the synchronized hold request and a serial-clock edge. The same applies to a pause and a deselection. The bench drives the hold pin low while the clock pin is high and then releases the clock. A correct design starts the pause on the falling clock cycle and counts no bit. The same pin order is applied on release. The bench also raises select during a pause and then checks three things at the ports: the lock, the cleared count, and the refusal of a reselect that comes while the hold pin is still low.

// File: rtl/hold_cond_pkg.sv
package hold_cond_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_PAUSED = 2'd2,
        ST_LOCKED = 2'd3
    } port_state_e;

    // bit positions of the synchronized pin bundle
    localparam int PIN_SCK  = 0;
    localparam int PIN_CS   = 1;
    localparam int PIN_HOLD = 2;
    localparam int PIN_SDI  = 3;
    localparam int PIN_NUM  = 4;

endpackage

// File: rtl/hold_cond_sync.sv
module hold_cond_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/hold_cond_edge.sv
module hold_cond_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/hold_cond_fsm.sv
module hold_cond_fsm
    import hold_cond_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_s,
    input  logic        cs_rise,
    input  logic        cs_fall,
    input  logic        hold_s,
    input  logic        sck_s,
    output port_state_e state,
    output logic        hold_active,
    output logic        iface_clear,
    output logic        locked_out
);
    typedef struct packed {
        port_state_e st;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (cs_fall) fsm_d.st = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (cs_rise)                 fsm_d.st = ST_IDLE;
                else if (!hold_s && !sck_s)  fsm_d.st = ST_PAUSED;
            end
            ST_PAUSED: begin
                if (cs_rise)                 fsm_d.st = ST_LOCKED;
                else if (hold_s && !sck_s)   fsm_d.st = ST_ACTIVE;
            end
            ST_LOCKED: begin
                if (hold_s && cs_s)          fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q.st <= ST_IDLE;
        else        fsm_q    <= fsm_d;
    end

    assign state       = fsm_q.st;
    assign hold_active = (fsm_q.st == ST_PAUSED);
    assign locked_out  = (fsm_q.st == ST_LOCKED);
    assign iface_clear = (fsm_q.st == ST_IDLE) || (fsm_q.st == ST_LOCKED);
endmodule

// File: rtl/hold_cond_rx.sv
module hold_cond_rx #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] partial,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } rx_regs_t;

    rx_regs_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (clear) begin
            rx_d.cnt = '0;
        end else if (shift_en) begin
            rx_d.shreg = {rx_q.shreg[WORD_W-2:0], bit_in};
            if (rx_q.cnt == LAST_BIT) begin
                rx_d.word = rx_d.shreg;
                rx_d.cnt  = '0;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign word    = rx_q.word;
    assign partial = rx_q.shreg;
    assign count   = rx_q.cnt;
endmodule

// File: rtl/hold_cond_ctrl.sv
module hold_cond_ctrl
    import hold_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 8,
    parameter int CNT_W       = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_pin,
    input  logic              cs_n_pin,
    input  logic              hold_n_pin,
    input  logic              sdi_pin,
    input  logic              tx_oe_in,
    output logic              hold_active,
    output logic              iface_clear,
    output logic              locked_out,
    output logic              sdo_oe,
    output logic              sck_rise_ok,
    output logic              sck_fall_ok,
    output logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] rx_partial,
    output logic [CNT_W-1:0]  rx_count
);
    // idle pin levels: clock low, deselected, not paused, data low
    localparam logic [PIN_NUM-1:0] PIN_IDLE = 4'b0110;
    localparam int                 EDGE_NUM = 2;

    logic [PIN_NUM-1:0]  pins_raw, pins_s;
    logic [EDGE_NUM-1:0] edge_rise, edge_fall;
    logic                sck_s, cs_s, hold_s, sdi_s;
    port_state_e         state;
    logic                running;

    assign pins_raw = {sdi_pin, hold_n_pin, cs_n_pin, sck_pin};

    hold_cond_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (PIN_NUM),
        .RST_VAL(PIN_IDLE)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pins_raw),
        .sync_out(pins_s)
    );

    assign sck_s  = pins_s[PIN_SCK];
    assign cs_s   = pins_s[PIN_CS];
    assign hold_s = pins_s[PIN_HOLD];
    assign sdi_s  = pins_s[PIN_SDI];

    // edge detectors on clock (index 0) and select (index 1)
    for (genvar g = 0; g < EDGE_NUM; g++) begin : g_edge
        hold_cond_edge #(
            .RST_VAL(PIN_IDLE[g])
        ) i_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .level(pins_s[g]),
            .rise (edge_rise[g]),
            .fall (edge_fall[g])
        );
    end

    hold_cond_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .cs_rise    (edge_rise[PIN_CS]),
        .cs_fall    (edge_fall[PIN_CS]),
        .hold_s     (hold_s),
        .sck_s      (sck_s),
        .state      (state),
        .hold_active(hold_active),
        .iface_clear(iface_clear),
        .locked_out (locked_out)
    );

    assign running     = (state == ST_ACTIVE);
    assign sck_rise_ok = running & edge_rise[PIN_SCK];
    assign sck_fall_ok = running & edge_fall[PIN_SCK];
    assign sdo_oe      = running & tx_oe_in;

    hold_cond_rx #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (iface_clear),
        .shift_en(sck_rise_ok),
        .bit_in  (sdi_s),
        .word    (rx_word),
        .partial (rx_partial),
        .count   (rx_count)
    );
endmodule

// File: rtl/hold_cond_chk.sv
module hold_cond_chk #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              hold_s,
    input logic              sck_s,
    input logic              hold_active,
    input logic              locked_out,
    input logic              sdo_oe,
    input logic              sck_rise_ok,
    input logic [WORD_W-1:0] rx_partial,
    input logic [CNT_W-1:0]  rx_count
);
    // R4 R5: a pause only begins from a selected port with clock low and hold low
    a_r4_enter_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> $past(!sck_s && !hold_s && !cs_s));

    // R6: a pause ends on deselection or on hold released with clock low
    a_r6_exit_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_active) |-> $past(cs_s || (hold_s && !sck_s)));

    // R7: output driver off and clock edges blocked during a pause
    a_r7_quiet_output: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!sdo_oe && !sck_rise_ok));

    // R7 R8: receive state frozen across a pause
    a_r7_frozen_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && $past(hold_active)) |-> ($stable(rx_count) && $stable(rx_partial)));

    // R9: deselecting during a pause locks the port
    a_r9_abort_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && cs_s) |=> (locked_out && !hold_active));

    // R9: a locked port has no bits counted
    a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        locked_out |=> (rx_count == '0));

    // R10: the lock persists while the hold pin stays low
    a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_out && !hold_s) |=> locked_out);
endmodule

bind hold_cond_ctrl hold_cond_chk #(
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
) i_hold_cond_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .hold_s     (hold_s),
    .sck_s      (sck_s),
    .hold_active(hold_active),
    .locked_out (locked_out),
    .sdo_oe     (sdo_oe),
    .sck_rise_ok(sck_rise_ok),
    .rx_partial (rx_partial),
    .rx_count   (rx_count)
);

// File: tb/test_hold_cond_ctrl.sv
module test_hold_cond_ctrl;
    localparam int WORD_W  = 8;
    localparam int CNT_W   = 3;
    localparam int WD_LIM  = 20000;
    localparam int SETTLE  = 5;
    localparam int NVEC    = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck_pin = 1'b0, cs_n_pin = 1'b1, hold_n_pin = 1'b1, sdi_pin = 1'b0, tx_oe_in = 1'b0;
    logic hold_active, iface_clear, locked_out, sdo_oe, sck_rise_ok, sck_fall_ok;
    logic [WORD_W-1:0] rx_word, rx_partial;
    logic [CNT_W-1:0]  rx_count;
    int checks = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    hold_cond_ctrl #(.WORD_W(WORD_W)) i_hold_cond_ctrl (
        .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .cs_n_pin(cs_n_pin),
        .hold_n_pin(hold_n_pin), .sdi_pin(sdi_pin), .tx_oe_in(tx_oe_in),
        .hold_active(hold_active), .iface_clear(iface_clear), .locked_out(locked_out),
        .sdo_oe(sdo_oe), .sck_rise_ok(sck_rise_ok), .sck_fall_ok(sck_fall_ok),
        .rx_word(rx_word), .rx_partial(rx_partial), .rx_count(rx_count)
    );

    // vector: [12:9] requirement, [8:4] cs_n hold_n sck sdi tx_oe, [3:0] exp hold clear lock oe
    localparam logic [12:0] VEC [NVEC] = '{
        {4'd2,  5'b10001, 4'b0100},  // R2 deselected: oe off
        {4'd3,  5'b10001, 4'b0100},  // R3 hold low while deselected (hold bit below)
        {4'd3,  5'b11001, 4'b0100},  // R3
        {4'd2,  5'b01001, 4'b0001},  // R2 select: oe follows request
        {4'd5,  5'b01101, 4'b0001},  // R5 clock high
        {4'd5,  5'b00101, 4'b0001},  // R5 hold low with clock high: deferred
        {4'd5,  5'b00001, 4'b1000},  // R5 clock low: paused
        {4'd7,  5'b00101, 4'b1000},  // R7 clock edge ignored
        {4'd6,  5'b01101, 4'b1000},  // R6 release with clock high: deferred
        {4'd6,  5'b01001, 4'b0001},  // R6 clock low: resumed
        {4'd4,  5'b00001, 4'b1000},  // R4 immediate entry
        {4'd6,  5'b01001, 4'b0001},  // R6 immediate exit
        {4'd4,  5'b00001, 4'b1000},  // R4
        {4'd9,  5'b10001, 4'b0110},  // R9 deselect during pause
        {4'd10, 5'b00001, 4'b0110},  // R10 reselect with hold low refused
        {4'd10, 5'b10001, 4'b0110},  // R10
        {4'd10, 5'b11001, 4'b0100},  // R10 hold released while deselected
        {4'd10, 5'b01001, 4'b0001},  // R10 fresh select
        {4'd2,  5'b01000, 4'b0000}   // R2 request dropped
    };

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdi_pin = b;
        wait_clks(4);
        sck_pin = 1'b1;
        wait_clks(4);
        sck_pin = 1'b0;
        wait_clks(4);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
        $finish;
    endtask

    initial begin
        repeat (WD_LIM) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        // R1 reset state
        check(1, hold_active, 0, "hold after reset");
        check(1, locked_out, 0, "lock after reset");
        check(1, iface_clear, 1, "clear after reset");
        check(1, sdo_oe, 0, "oe after reset");
        check(1, rx_count, 0, "count after reset");
        check(1, rx_word, 0, "word after reset");

        for (int i = 0; i < NVEC; i++) begin
            cs_n_pin   = VEC[i][8];
            hold_n_pin = VEC[i][7];
            sck_pin    = VEC[i][6];
            sdi_pin    = VEC[i][5];
            tx_oe_in   = VEC[i][4];
            if (i == 1) hold_n_pin = 1'b0;
            wait_clks(SETTLE);
            check(int'(VEC[i][12:9]), hold_active, VEC[i][3], $sformatf("vec %0d hold", i));
            check(int'(VEC[i][12:9]), iface_clear, VEC[i][2], $sformatf("vec %0d clear", i));
            check(int'(VEC[i][12:9]), locked_out,  VEC[i][1], $sformatf("vec %0d lock", i));
            check(int'(VEC[i][12:9]), sdo_oe,      VEC[i][0], $sformatf("vec %0d oe", i));
        end

        // fresh selection
        cs_n_pin = 1'b1; wait_clks(SETTLE);
        cs_n_pin = 1'b0; wait_clks(SETTLE);
        // R11 MSB-first word assembly
        send_bits(8'hA5, 8);
        check(11, rx_word, 8'hA5, "word A5");
        check(11, rx_count, 0, "count wrap");
        // R8 partial word, then pause
        send_bits(8'h3C >> 5, 3);
        check(8, rx_count, 3, "count before pause");
        check(8, rx_partial[2:0], 3'b001, "partial before pause");
        hold_n_pin = 1'b0; wait_clks(SETTLE);
        check(4, hold_active, 1, "paused mid word");
        // R7 clock and data ignored while paused
        send_bits(8'hFF, 3);
        check(7, rx_count, 3, "count frozen");
        check(7, rx_partial[2:0], 3'b001, "partial frozen");
        check(7, rx_word, 8'hA5, "word frozen");
        hold_n_pin = 1'b1; wait_clks(SETTLE);
        check(6, hold_active, 0, "resumed");
        // R8 the rest of the word completes correctly
        send_bits(8'h3C, 5);
        check(8, rx_word, 8'h3C, "word 3C after pause");
        check(8, rx_count, 0, "count after resume");
        // R9 abort mid word
        send_bits(8'h02, 2);
        check(9, rx_count, 2, "count before abort");
        hold_n_pin = 1'b0; wait_clks(SETTLE);
        cs_n_pin = 1'b1; wait_clks(SETTLE);
        check(9, locked_out, 1, "locked after abort");
        check(9, rx_count, 0, "count cleared by abort");
        // R10 clock edges while locked ignored, reselect refused
        cs_n_pin = 1'b0; wait_clks(SETTLE);
        send_bits(8'hFF, 2);
        check(10, rx_count, 0, "no bits while locked");
        check(10, locked_out, 1, "still locked");
        // hold released while still selected: lock stays until deselect
        hold_n_pin = 1'b1; wait_clks(SETTLE);
        check(10, locked_out, 1, "lock needs deselect");
        cs_n_pin = 1'b1; wait_clks(SETTLE);
        check(10, locked_out, 0, "lock cleared");
        cs_n_pin = 1'b0; wait_clks(SETTLE);
        send_bit(1'b1);
        check(10, rx_count, 1, "restart counts bits");

        finish_run();
    end
endmodule